// File: doc/BRIEF.md
# Filtered Input Capture Channel

This block is one input-capture channel of a timer. A free-running counter value comes in from outside, together with an asynchronous pin. The pin passes through a two-flop synchroniser and then a digital glitch filter, which accepts a new level only after a run of consecutive equal samples. An edge selector then picks rising, falling or both edges. An edge prescaler lets only every 1st, 2nd, 4th or 8th selected edge through. Each event that passes copies the counter value into a capture register.

The channel keeps a capture flag and an overcapture flag. It drives an interrupt request and a one-cycle DMA request, each gated by its own enable bit. A four-word register interface holds the configuration, the flags and the capture register. It also lets software force a capture event that takes the same path as a pin edge, without going through the filter or the prescaler. Reading the capture register clears the capture flag. The overcapture flag is cleared only by an explicit write. When a capture and a clear of the capture flag happen in the same cycle, the capture takes priority.

Top module: `icap_channel`

## Requirements
- R1: After reset the configuration word, both flags and the capture register read 0, and irqReq and dmaReq are low.
- R2: Configuration bits [1:0] form the input-select field. When the field is 00, a bus write to address 3 loads the capture register. When the field is nonzero, such writes are ignored.
- R3: Select code 01 routes the filtered pin to the capture logic. Select codes 10 and 11 leave the channel in input mode but ignore the pin, so only software events capture.
- R4: Configuration bits [5:2] form the filter code. Codes 0, 1, 2 and 3 need 1, 2, 4 and 8 consecutive samples taken at the clock rate. Codes 4 to 15 need 6 samples (even code) or 8 samples (odd code), taken once every SAMP_DIV clocks. A shorter pulse is dropped.
- R5: Configuration bits [7:6] select the active edge: 00 rising, 01 falling, 11 both edges, 10 rising.
- R6: Configuration bits [9:8] set the prescaler: 00 captures on every active edge, 01 on every 2nd, 10 on every 4th, 11 on every 8th. The edge count returns to zero while the channel is disabled.
- R7: Configuration bit 10 enables the channel. While it is 0, no capture of any kind takes place.
- R8: A pin capture loads the counter value present at the clock edge that comes n+2 edges after the first edge at which the pin shows its new level. Here n is the required sample count at the clock rate.
- R9: Address 1 holds the capture flag in bit 0 and the overcapture flag in bit 1. A capture sets the capture flag. A capture that occurs while the capture flag is already set also sets the overcapture flag.
- R10: A bus read of address 3 clears the capture flag and leaves the overcapture flag unchanged. Writing 0 to a flag bit at address 1 clears that flag. Writing 1 to it has no effect.
- R11: If a capture and a clear of the capture flag (by read or by write) fall on the same clock edge, the capture flag ends up set.
- R12: irqReq is high exactly while the capture flag is set and configuration bit 11 is 1. When configuration bit 12 is 1, dmaReq is a one-cycle pulse in the cycle after each capture. When bit 12 is 0, dmaReq stays low.
- R13: Writing 1 to bit 0 of address 2 captures the counter value at that write edge. This bypasses the filter and the prescaler. It needs the channel enabled and the select field nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rstN | input | 1 | Active-low synchronous reset |
| cntVal | input | CNT_W | Free-running counter value to be captured |
| pinIn | input | 1 | Asynchronous capture pin |
| busWr | input | 1 | Register write strobe |
| busRd | input | 1 | Register read strobe (side effects) |
| busAddr | input | 2 | Register address: 0 config, 1 flags, 2 event, 3 capture |
| busWdata | input | 16 | Write data |
| busRdata | output | 16 | Read data for busAddr, combinational |
| irqReq | output | 1 | Interrupt request |
| dmaReq | output | 1 | DMA request pulse |

## Verification
Two things can happen on the same clock edge: a capture that sets the capture flag, and a clear of that flag, either by writing 0 to the flags word or by reading the capture register. To make them collide, the bench drives a pin edge and then places the bus access exactly on the edge where the filtered transition produces the capture. It does this once for the write-clear path and once for the read-clear path. The result is judged by reading the flags word afterwards. Bit 0 must still be set, and in the second case bit 1 must also be set, because that capture found the flag already set.

// File: rtl/icap_pkg.sv
package icap_pkg;
  localparam int REG_W = 16;

  localparam logic [1:0] ADDR_CFG  = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_EVT  = 2'd2;
  localparam logic [1:0] ADDR_CAP  = 2'd3;

  // configuration word, MSB first so it maps onto bits [12:0]
  typedef struct packed {
    logic       dmaEn;
    logic       irqEn;
    logic       chEn;
    logic [1:0] pscCode;
    logic [1:0] polSel;
    logic [3:0] fltCode;
    logic [1:0] selMode;
  } cfg_t;

  localparam int CFG_W = $bits(cfg_t);

  // strobes from control to datapath
  typedef struct packed {
    logic capture;
    logic clrCap;
    logic clrOvr;
    logic capLoad;
  } strobe_t;
endpackage

// File: rtl/icap_filter.sv
module icap_filter #(
  parameter int SAMP_DIV = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       rawIn,
  input  logic [3:0] fltCode,
  output logic       level
);
  localparam int DIV_W = (SAMP_DIV > 1) ? $clog2(SAMP_DIV) : 1;
  localparam int RUN_W = 4;

  logic             syncA, syncIn;
  logic [DIV_W-1:0] divCnt;
  logic             divTick, sampleEn, slowMode;
  logic [RUN_W-1:0] need, runCnt;

  // two-flop synchroniser
  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncA  <= 1'b0;
      syncIn <= 1'b0;
    end else begin
      syncA  <= rawIn;
      syncIn <= syncA;
    end
  end

  // divided sampling tick
  always_ff @(posedge clk) begin
    if (!rstN) divCnt <= '0;
    else if (divTick) divCnt <= '0;
    else divCnt <= divCnt + 1'b1;
  end
  assign divTick = (divCnt == DIV_W'(SAMP_DIV - 1));

  always_comb begin
    case (fltCode)
      4'd0:    need = 4'd1;
      4'd1:    need = 4'd2;
      4'd2:    need = 4'd4;
      4'd3:    need = 4'd8;
      default: need = fltCode[0] ? 4'd8 : 4'd6;
    endcase
  end
  assign slowMode = (fltCode[3:2] != 2'b00);
  assign sampleEn = slowMode ? divTick : 1'b1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      level  <= 1'b0;
      runCnt <= '0;
    end else if (sampleEn) begin
      if (syncIn != level) begin
        if (runCnt == need - 1'b1) begin
          level  <= syncIn;
          runCnt <= '0;
        end else begin
          runCnt <= runCnt + 1'b1;
        end
      end else begin
        runCnt <= '0;
      end
    end
  end

  // R4
  property pFltFollow;
    @(posedge clk) disable iff (!rstN)
      (level != $past(level)) |-> ($past(syncIn) == level && $past(sampleEn));
  endproperty
  flt_follow_chk: assert property (pFltFollow);

  // R4
  property pFltHold;
    @(posedge clk) disable iff (!rstN)
      (sampleEn && syncIn != level && runCnt != need - 1'b1) |=> $stable(level);
  endproperty
  flt_short_run_chk: assert property (pFltHold);
endmodule

// File: rtl/icap_ctrl.sv
module icap_ctrl
  import icap_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             busWr,
  input  logic             busRd,
  input  logic [1:0]       busAddr,
  input  logic [REG_W-1:0] busWdata,
  output logic [REG_W-1:0] busRdata,
  input  logic             filtLvl,
  input  logic [CNT_W-1:0] capVal,
  input  logic             capFlag,
  input  logic             ovrFlag,
  output cfg_t             cfg,
  output strobe_t          strb,
  output logic [REG_W-1:0] loadData
);
  localparam int PSC_W = 3;

  logic             prevLvl, riseE, fallE, actEdge;
  logic             inMode, armed, pinRouted, pinEdge, pinEvt, swEvt;
  logic [PSC_W-1:0] pscCnt, pscMask;
  logic             wrCfg, wrStat, wrEvt, wrCap, rdCap;

  assign wrCfg  = busWr && busAddr == ADDR_CFG;
  assign wrStat = busWr && busAddr == ADDR_STAT;
  assign wrEvt  = busWr && busAddr == ADDR_EVT;
  assign wrCap  = busWr && busAddr == ADDR_CAP;
  assign rdCap  = busRd && busAddr == ADDR_CAP;

  always_ff @(posedge clk) begin
    if (!rstN) cfg <= '0;
    else if (wrCfg) cfg <= cfg_t'(busWdata[CFG_W-1:0]);
  end

  // edge detection on the filtered level
  always_ff @(posedge clk) begin
    if (!rstN) prevLvl <= 1'b0;
    else prevLvl <= filtLvl;
  end
  assign riseE = filtLvl && !prevLvl;
  assign fallE = !filtLvl && prevLvl;

  always_comb begin
    case (cfg.polSel)
      2'b01:   actEdge = fallE;
      2'b11:   actEdge = riseE || fallE;
      default: actEdge = riseE;
    endcase
  end

  assign inMode    = (cfg.selMode != 2'b00);
  assign armed     = inMode && cfg.chEn;
  assign pinRouted = (cfg.selMode == 2'b01);
  assign pinEdge   = armed && pinRouted && actEdge;

  // edge prescaler
  always_comb begin
    case (cfg.pscCode)
      2'd0:    pscMask = 3'b000;
      2'd1:    pscMask = 3'b001;
      2'd2:    pscMask = 3'b011;
      default: pscMask = 3'b111;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN || !armed) pscCnt <= '0;
    else if (pinEdge) pscCnt <= ((pscCnt & pscMask) == pscMask) ? '0 : pscCnt + 1'b1;
  end

  assign pinEvt = pinEdge && ((pscCnt & pscMask) == pscMask);
  assign swEvt  = wrEvt && busWdata[0] && armed;

  always_comb begin
    strb.capture = pinEvt || swEvt;
    strb.clrCap  = rdCap || (wrStat && !busWdata[0]);
    strb.clrOvr  = wrStat && !busWdata[1];
    strb.capLoad = wrCap && !inMode;
  end
  assign loadData = busWdata;

  always_comb begin
    case (busAddr)
      ADDR_CFG:  busRdata = REG_W'(cfg);
      ADDR_STAT: busRdata = REG_W'({ovrFlag, capFlag});
      ADDR_CAP:  busRdata = REG_W'(capVal);
      default:   busRdata = '0;
    endcase
  end

  // R7
  property pNoCapOff;
    @(posedge clk) disable iff (!rstN) !cfg.chEn |-> !strb.capture;
  endproperty
  no_cap_disabled_chk: assert property (pNoCapOff);

  // R2
  property pNoLoadIn;
    @(posedge clk) disable iff (!rstN) (cfg.selMode != 2'b00) |-> !strb.capLoad;
  endproperty
  no_load_input_chk: assert property (pNoLoadIn);

  // R13
  property pSwEvt;
    @(posedge clk) disable iff (!rstN)
      (busWr && busAddr == ADDR_EVT && busWdata[0] && cfg.chEn && cfg.selMode != 2'b00)
        |-> strb.capture;
  endproperty
  sw_event_chk: assert property (pSwEvt);

  // R3
  property pPinGate;
    @(posedge clk) disable iff (!rstN)
      (cfg.selMode != 2'b01 && !(busWr && busAddr == ADDR_EVT)) |-> !strb.capture;
  endproperty
  pin_route_chk: assert property (pPinGate);
endmodule

// File: rtl/icap_dpath.sv
module icap_dpath
  import icap_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] cntVal,
  input  logic [REG_W-1:0] loadData,
  input  strobe_t          strb,
  input  logic             irqEn,
  input  logic             dmaEn,
  output logic [CNT_W-1:0] capReg,
  output logic             capFlag,
  output logic             ovrFlag,
  output logic             irqReq,
  output logic             dmaReq
);
  always_ff @(posedge clk) begin
    if (!rstN) capReg <= '0;
    else if (strb.capture) capReg <= cntVal;
    else if (strb.capLoad) capReg <= loadData[CNT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      capFlag <= 1'b0;
      ovrFlag <= 1'b0;
      dmaReq  <= 1'b0;
    end else begin
      if (strb.capture) capFlag <= 1'b1;
      else if (strb.clrCap) capFlag <= 1'b0;

      if (strb.capture && capFlag) ovrFlag <= 1'b1;
      else if (strb.clrOvr) ovrFlag <= 1'b0;

      dmaReq <= strb.capture && dmaEn;
    end
  end

  assign irqReq = capFlag && irqEn;

  // R8
  property pCapVal;
    @(posedge clk) disable iff (!rstN) strb.capture |=> capReg == $past(cntVal);
  endproperty
  cap_value_chk: assert property (pCapVal);

  // R11
  property pCapWins;
    @(posedge clk) disable iff (!rstN) strb.capture |=> capFlag;
  endproperty
  cap_wins_chk: assert property (pCapWins);

  // R9
  property pOvr;
    @(posedge clk) disable iff (!rstN) (strb.capture && capFlag) |=> ovrFlag;
  endproperty
  ovr_set_chk: assert property (pOvr);

  // R12
  property pDma;
    @(posedge clk) disable iff (!rstN) dmaReq |-> $past(strb.capture);
  endproperty
  dma_pulse_chk: assert property (pDma);
endmodule

// File: rtl/icap_channel.sv
module icap_channel
  import icap_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int SAMP_DIV = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] cntVal,
  input  logic             pinIn,
  input  logic             busWr,
  input  logic             busRd,
  input  logic [1:0]       busAddr,
  input  logic [REG_W-1:0] busWdata,
  output logic [REG_W-1:0] busRdata,
  output logic             irqReq,
  output logic             dmaReq
);
  cfg_t             cfg;
  strobe_t          strb;
  logic             filtLvl, capFlag, ovrFlag;
  logic [CNT_W-1:0] capReg;
  logic [REG_W-1:0] loadData;

  icap_filter #(.SAMP_DIV(SAMP_DIV)) uFilt (
    .clk(clk), .rstN(rstN), .rawIn(pinIn), .fltCode(cfg.fltCode), .level(filtLvl)
  );

  icap_ctrl #(.CNT_W(CNT_W)) uCtrl (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busRd(busRd), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .filtLvl(filtLvl), .capVal(capReg),
    .capFlag(capFlag), .ovrFlag(ovrFlag), .cfg(cfg), .strb(strb), .loadData(loadData)
  );

  icap_dpath #(.CNT_W(CNT_W)) uDp (
    .clk(clk), .rstN(rstN), .cntVal(cntVal), .loadData(loadData), .strb(strb),
    .irqEn(cfg.irqEn), .dmaEn(cfg.dmaEn), .capReg(capReg), .capFlag(capFlag),
    .ovrFlag(ovrFlag), .irqReq(irqReq), .dmaReq(dmaReq)
  );
endmodule

// File: tb/sim_icap_channel.sv
module sim_icap_channel;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 16;
  localparam int SAMP_DIV = 4;
  localparam logic [1:0] A_CFG = 2'd0, A_STAT = 2'd1, A_EVT = 2'd2, A_CAP = 2'd3;

  logic clk = 1'b0, rstN = 1'b0;
  logic [CNT_W-1:0] cntVal = '0;
  logic pinIn = 1'b0, busWr = 1'b0, busRd = 1'b0;
  logic [1:0] busAddr = A_CAP;
  logic [15:0] busWdata = '0;
  logic [15:0] busRdata;
  logic irqReq, dmaReq;

  int checks = 0, errors = 0, capSeen = 0;
  bit finished = 1'b0;
  logic [15:0] valQ[$];
  bit anyQ[$];
  string tagQ[$];
  logic [15:0] mv;
  bit ma;
  string mt;

  icap_channel #(.CNT_W(CNT_W), .SAMP_DIV(SAMP_DIV)) u0 (
    .clk(clk), .rstN(rstN), .cntVal(cntVal), .pinIn(pinIn), .busWr(busWr), .busRd(busRd),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata), .irqReq(irqReq), .dmaReq(dmaReq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(negedge clk) cntVal <= cntVal + 1'b1;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] cfgWord(input int sel, input int flt, input int pol,
                                           input int psc, input bit en, input bit irq, input bit dma);
    return {3'b000, dma, irq, en, 2'(psc), 2'(pol), 4'(flt), 2'(sel)};
  endfunction

  task automatic push(input logic [15:0] v, input bit any, input string tag);
    valQ.push_back(v); anyQ.push_back(any); tagQ.push_back(tag);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busWrite(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk); busWr = 1'b0; busAddr = A_CAP;
  endtask

  task automatic busRead(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk); busRd = 1'b1; busAddr = a; #1 d = busRdata;
    @(negedge clk); busRd = 1'b0; busAddr = A_CAP;
  endtask

  // drive a pin level; if a capture is expected, push counter + 2 + n
  task automatic pinSet(input logic lvl, input int n, input bit expCap, input string tag);
    @(negedge clk); pinIn = lvl; #1;
    if (expCap) push(cntVal + 16'(2 + n), 1'b0, tag);
    idle(n + 8);
  endtask

  task automatic swEvent(input bit expCap, input string tag);
    @(negedge clk); busWr = 1'b1; busAddr = A_EVT; busWdata = 16'h0001; #1;
    if (expCap) push(cntVal, 1'b0, tag);
    @(negedge clk); busWr = 1'b0; busAddr = A_CAP;
    idle(4);
  endtask

  // monitor: each DMA pulse is one capture; compare the capture register
  initial begin
    forever begin
      @(negedge clk); #2;
      if (rstN && dmaReq) begin
        capSeen++;
        if (valQ.size() == 0) begin
          checks++; errors++;
          $display("FAIL R12 unexpected capture actual=%0h expected=none", busRdata);
        end else begin
          mv = valQ.pop_front(); ma = anyQ.pop_front(); mt = tagQ.pop_front();
          if (!ma) chk(mt, "captured value", busRdata, mv);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    int base;
    logic [15:0] expV;

    idle(3); rstN = 1'b1; idle(1);
    // R1 reset state
    chk("R1", "irqReq", irqReq, 0);
    chk("R1", "dmaReq", dmaReq, 0);
    busRead(A_CFG, d);  chk("R1", "config", d, 0);
    busRead(A_STAT, d); chk("R1", "flags", d, 0);
    busRead(A_CAP, d);  chk("R1", "capture reg", d, 0);

    // R3 R8 basic rising capture
    busWrite(A_CFG, cfgWord(1, 0, 0, 0, 1, 1, 1));
    busRead(A_CFG, d); chk("R3", "config readback", d, cfgWord(1, 0, 0, 0, 1, 1, 1));
    pinSet(1'b1, 1, 1'b1, "R8");
    busRead(A_STAT, d); chk("R9", "flag after capture", d, 16'h0001);
    chk("R12", "irq with flag", irqReq, 1);
    base = capSeen;
    pinSet(1'b0, 1, 1'b0, "R5");
    chk("R5", "falling ignored when rising selected", capSeen, base);

    // R10 read clears capture flag
    busRead(A_CAP, d);
    busRead(A_STAT, d); chk("R10", "flag after cap read", d, 0);
    chk("R12", "irq after clear", irqReq, 0);

    // R9 overcapture
    pinSet(1'b1, 1, 1'b1, "R9");
    pinSet(1'b0, 1, 1'b0, "R9");
    pinSet(1'b1, 1, 1'b1, "R9");
    busRead(A_STAT, d); chk("R9", "overcapture", d, 16'h0003);
    busWrite(A_STAT, 16'h0001);
    busRead(A_STAT, d); chk("R10", "write0 clears ovr only", d, 16'h0001);
    pinSet(1'b0, 1, 1'b0, "R9");
    pinSet(1'b1, 1, 1'b1, "R9");
    busRead(A_CAP, d);
    busRead(A_STAT, d); chk("R10", "cap read keeps ovr", d, 16'h0002);
    busWrite(A_STAT, 16'h0000);
    busRead(A_STAT, d); chk("R10", "flags cleared", d, 0);
    pinSet(1'b0, 1, 1'b0, "R9");

    // R4 filter code 3: eight samples
    busWrite(A_CFG, cfgWord(1, 3, 0, 0, 1, 1, 1));
    base = capSeen;
    @(negedge clk); pinIn = 1'b1; idle(5); pinIn = 1'b0; idle(15);
    chk("R4", "5-cycle glitch rejected", capSeen, base);
    pinSet(1'b1, 8, 1'b1, "R4");
    chk("R4", "8-sample edge captured", capSeen, base + 1);
    pinSet(1'b0, 8, 1'b0, "R4");

    // R5 polarity
    busWrite(A_CFG, cfgWord(1, 0, 1, 0, 1, 1, 1));
    pinSet(1'b1, 1, 1'b0, "R5");
    pinSet(1'b0, 1, 1'b1, "R5");
    busWrite(A_CFG, cfgWord(1, 0, 3, 0, 1, 1, 1));
    base = capSeen;
    pinSet(1'b1, 1, 1'b1, "R5");
    pinSet(1'b0, 1, 1'b1, "R5");
    chk("R5", "both edges", capSeen, base + 2);
    busWrite(A_CFG, cfgWord(1, 0, 2, 0, 1, 1, 1));
    base = capSeen;
    pinSet(1'b1, 1, 1'b1, "R5");
    pinSet(1'b0, 1, 1'b0, "R5");
    chk("R5", "code 10 acts as rising", capSeen, base + 1);

    // R6 prescaler
    busWrite(A_CFG, cfgWord(1, 0, 0, 2, 1, 1, 1));
    base = capSeen;
    for (int i = 0; i < 4; i++) begin
      pinSet(1'b1, 1, i == 3, "R6");
      pinSet(1'b0, 1, 1'b0, "R6");
    end
    chk("R6", "every 4th edge", capSeen, base + 1);
    busWrite(A_CFG, cfgWord(1, 0, 0, 1, 1, 1, 1));
    pinSet(1'b1, 1, 1'b0, "R6"); pinSet(1'b0, 1, 1'b0, "R6");
    busWrite(A_CFG, cfgWord(1, 0, 0, 1, 0, 1, 1));
    busWrite(A_CFG, cfgWord(1, 0, 0, 1, 1, 1, 1));
    base = capSeen;
    pinSet(1'b1, 1, 1'b0, "R6"); pinSet(1'b0, 1, 1'b0, "R6");
    chk("R6", "count restarted by disable", capSeen, base);
    pinSet(1'b1, 1, 1'b1, "R6"); pinSet(1'b0, 1, 1'b0, "R6");
    chk("R6", "every 2nd edge", capSeen, base + 1);

    // R7 channel disabled
    busWrite(A_CFG, cfgWord(1, 0, 0, 0, 0, 1, 1));
    base = capSeen;
    pinSet(1'b1, 1, 1'b0, "R7"); pinSet(1'b0, 1, 1'b0, "R7");
    swEvent(1'b0, "R7");
    chk("R7", "no capture when disabled", capSeen, base);

    // R2 capture register writable only in output mode
    busWrite(A_CFG, cfgWord(0, 0, 0, 0, 1, 1, 1));
    busWrite(A_CAP, 16'hBEEF);
    busRead(A_CAP, d); chk("R2", "load in output mode", d, 16'hBEEF);
    swEvent(1'b0, "R13");
    chk("R13", "no sw capture in output mode", capSeen, base);
    busWrite(A_CFG, cfgWord(1, 0, 0, 0, 1, 1, 1));
    busWrite(A_CAP, 16'h1234);
    busRead(A_CAP, d); chk("R2", "write ignored in input mode", d, 16'hBEEF);

    // R3 R13 select 10: pin ignored, software event bypasses prescaler
    busWrite(A_CFG, cfgWord(2, 0, 0, 3, 1, 1, 1));
    base = capSeen;
    pinSet(1'b1, 1, 1'b0, "R3"); pinSet(1'b0, 1, 1'b0, "R3");
    chk("R3", "pin ignored with select 10", capSeen, base);
    swEvent(1'b1, "R13");
    chk("R13", "sw event captured", capSeen, base + 1);
    busWrite(A_STAT, 16'h0000);

    // R11 capture against write-clear in same cycle
    busWrite(A_CFG, cfgWord(1, 0, 0, 0, 1, 1, 1));
    @(negedge clk); pinIn = 1'b1; #1 push(cntVal + 16'd3, 1'b0, "R11");
    repeat (3) @(negedge clk);
    busWr = 1'b1; busAddr = A_STAT; busWdata = 16'h0000;
    @(negedge clk); busWr = 1'b0; busAddr = A_CAP;
    idle(4);
    busRead(A_STAT, d); chk("R11", "capture beats write clear", d, 16'h0001);
    pinSet(1'b0, 1, 1'b0, "R11");
    @(negedge clk); pinIn = 1'b1; #1 push(cntVal + 16'd3, 1'b0, "R11");
    repeat (3) @(negedge clk);
    busRd = 1'b1; busAddr = A_CAP;
    @(negedge clk); busRd = 1'b0; busAddr = A_CAP;
    idle(4);
    busRead(A_STAT, d); chk("R11", "capture beats read clear", d, 16'h0003);
    pinSet(1'b0, 1, 1'b0, "R11");
    busWrite(A_STAT, 16'h0000);

    // R12 interrupt and DMA disabled
    busWrite(A_CFG, cfgWord(1, 0, 0, 0, 1, 0, 0));
    base = capSeen;
    @(negedge clk); pinIn = 1'b1; #1 expV = cntVal + 16'd3;
    idle(8);
    chk("R12", "no dma pulse when disabled", capSeen, base);
    chk("R12", "irq masked", irqReq, 0);
    busRead(A_STAT, d); chk("R12", "flag set without irq", d, 16'h0001);
    busRead(A_CAP, d); chk("R8", "capture value without dma", d, expV);
    pinSet(1'b0, 1, 1'b0, "R12");

    // R4 slow filter: code 4, six samples every SAMP_DIV clocks
    busWrite(A_CFG, cfgWord(1, 4, 0, 0, 1, 1, 1));
    base = capSeen;
    @(negedge clk); pinIn = 1'b1; idle(12); pinIn = 1'b0; idle(40);
    chk("R4", "slow filter rejects 12-cycle pulse", capSeen, base);
    @(negedge clk); pinIn = 1'b1; push(16'h0, 1'b1, "R4");
    idle(6 * SAMP_DIV + 10);
    chk("R4", "slow filter accepts steady level", capSeen, base + 1);

    idle(5);
    chk("R12", "no outstanding expected captures", valQ.size(), 0);
    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule